// File: doc/BRIEF.md
# Clear-on-Read Buffer Event Register

This block is the sticky event register that an Ethernet controller's host interface exposes for its transmit and receive buffers. The datapath reports each event as a single-cycle pulse. The block latches the pulse into a flag, and the flag stays set until the host reads the register. A read returns the full 16-bit value and, as a side effect, clears every event flag at once. The host must therefore deal with all pending events from the value that one read returns.

The six low bits are not events. They hold a fixed code that lets software confirm which register it is looking at. A companion configuration word supplies one enable bit for each event, at the same bit position as that event. The block raises a single interrupt request while any enabled event is pending.

One event is produced inside the block rather than by the datapath. A byte counter follows each incoming frame and raises the early-receive flag when the 128th byte of that frame arrives.

Top module: `evt_status_reg`

## Requirements
- R1: `rd_data[5:0]` always reads `6'b001100`, with the LSB at bit 0. A read never changes these bits.
- R2: `rd_data[14:12]` always reads zero. After reset, `rd_data` is `16'h000C`.
- R3: Each event pulse sets one bit, visible on `rd_data` from the cycle after the pulse. The mapping is: `ev_sw` sets bit 6, `ev_rxdma` sets bit 7, `ev_txrdy` sets bit 8, `ev_txunder` sets bit 9, `ev_rxmiss` sets bit 10, the internal 128-byte event sets bit 11, and `ev_dest` sets bit 15. A set bit stays set until a read.
- R4: When `rd_stb` is high for a cycle, `rd_data` in that cycle shows the current value. From the next cycle, every event bit is zero.
- R5: An event pulse that arrives in the same cycle as `rd_stb` is not lost. Its bit is set after the clearing read.
- R6: `irq` is high exactly when some event bit is set and the `cfg_en` bit at the same position is 1. The `cfg_en` bits at non-event positions (5..0 and 14..12) have no effect.
- R7: After a clearing read with no coinciding event, `irq` is low from the next cycle.
- R8: Bytes are counted on `rx_byte_vld`. A byte that arrives with `rx_sof` is the first byte of a new frame. Bit 11 is set in the cycle after the 128th byte of the frame, and not before.
- R9: The 128-byte event fires at most once per frame. Bytes after the 128th do not set bit 11 again.
- R10: `rx_sof` in the middle of a frame restarts the byte count for the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_stb | input | 1 | Host read strobe; clears event bits at the clock edge |
| cfg_en | input | 16 | Interrupt enables, one per event bit position |
| ev_sw | input | 1 | Software-interrupt event pulse |
| ev_rxdma | input | 1 | Receive DMA frame-done pulse |
| ev_txrdy | input | 1 | Ready-for-transmit pulse |
| ev_txunder | input | 1 | Transmit underrun pulse |
| ev_rxmiss | input | 1 | Receive frame lost pulse |
| ev_dest | input | 1 | Destination filter passed pulse |
| rx_sof | input | 1 | Start of incoming frame |
| rx_byte_vld | input | 1 | One received byte this cycle |
| rd_data | output | 16 | Current register value |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is the one where the 128th byte, or some other event, lands in exactly the same cycle as a clearing read. The bench produces it by driving a pulse on the same falling edge that raises `rd_stb`. It then checks both the value returned by the read and the bit that survives the read.

Saturation of the byte counter needs long frames. The bench streams 128 bytes, keeps streaming past that point, and then restarts the frame in the middle of the count. This shows that bit 11 is set only once per frame.

The enable bits that sit on top of the identifier's 1 bits are also set during the test, to show they do not raise `irq`.

// File: rtl/evtreg_pkg.sv
package evtreg_pkg;

    localparam int REG_W  = 16;
    localparam int NUM_EV = 7;

    localparam logic [5:0] ID_CODE = 6'b001100;

    // event index -> register bit
    localparam int EV_SW    = 0;
    localparam int EV_RXDMA = 1;
    localparam int EV_TXRDY = 2;
    localparam int EV_TXUND = 3;
    localparam int EV_RXMIS = 4;
    localparam int EV_RX128 = 5;
    localparam int EV_DEST  = 6;

    localparam int EV_POS [NUM_EV] = '{6, 7, 8, 9, 10, 11, 15};

    function automatic logic [REG_W-1:0] place_events(input logic [NUM_EV-1:0] f);
        logic [REG_W-1:0] v;
        v = '0;
        for (int i = 0; i < NUM_EV; i++) begin
            v[EV_POS[i]] = f[i];
        end
        v[5:0] = ID_CODE;
        return v;
    endfunction

    localparam logic [REG_W-1:0] EV_MASK = place_events('1) & ~{{(REG_W-6){1'b0}}, 6'h3F};

endpackage

// File: rtl/rx_byte_watch.sv
module rx_byte_watch #(
    parameter int THRESH = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sof_i,
    input  logic byte_vld_i,
    output logic hit_o
);
    localparam int CW = $clog2(THRESH + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } watch_st_t;

    watch_st_t st_d, st_q;
    logic [CW-1:0] base;

    always_comb begin
        st_d  = st_q;
        base  = sof_i ? '0 : st_q.cnt;
        hit_o = 1'b0;
        st_d.cnt = base;
        if (byte_vld_i) begin
            if (base == CW'(THRESH - 1)) begin
                hit_o = 1'b1;
            end
            if (base != CW'(THRESH)) begin
                st_d.cnt = base + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // two hits in a row would mean the count did not saturate
    assert_single_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && !sof_i) |=> !(hit_o && !sof_i));

endmodule

// File: rtl/evt_flag_bank.sv
module evt_flag_bank #(
    parameter int NUM = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] set_i,
    input  logic           clr_i,
    output logic [NUM-1:0] flags_o
);
    typedef struct packed {
        logic [NUM-1:0] flags;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.flags = set_i;
        end else begin
            st_d.flags = st_q.flags | set_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;

    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((st_q.flags & $past(st_q.flags)) == $past(st_q.flags)));

    assert_clear_keeps_new_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q.flags == $past(set_i)));

endmodule

// File: rtl/evt_irq_merge.sv
module evt_irq_merge
    import evtreg_pkg::*;
(
    input  logic [REG_W-1:0] value_i,
    input  logic [REG_W-1:0] en_i,
    output logic             irq_o
);
    always_comb begin
        irq_o = |(value_i & en_i & EV_MASK);
    end
endmodule

// File: rtl/evt_status_reg.sv
module evt_status_reg
    import evtreg_pkg::*;
#(
    parameter int RX_THRESH = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_stb,
    input  logic [15:0] cfg_en,
    input  logic        ev_sw,
    input  logic        ev_rxdma,
    input  logic        ev_txrdy,
    input  logic        ev_txunder,
    input  logic        ev_rxmiss,
    input  logic        ev_dest,
    input  logic        rx_sof,
    input  logic        rx_byte_vld,
    output logic [15:0] rd_data,
    output logic        irq
);
    logic              rx_hit;
    logic [NUM_EV-1:0] ev_set;
    logic [NUM_EV-1:0] ev_flags;

    rx_byte_watch #(.THRESH(RX_THRESH)) u_watch (
        .clk        (clk),
        .rst_n      (rst_n),
        .sof_i      (rx_sof),
        .byte_vld_i (rx_byte_vld),
        .hit_o      (rx_hit)
    );

    always_comb begin
        ev_set           = '0;
        ev_set[EV_SW]    = ev_sw;
        ev_set[EV_RXDMA] = ev_rxdma;
        ev_set[EV_TXRDY] = ev_txrdy;
        ev_set[EV_TXUND] = ev_txunder;
        ev_set[EV_RXMIS] = ev_rxmiss;
        ev_set[EV_RX128] = rx_hit;
        ev_set[EV_DEST]  = ev_dest;
    end

    evt_flag_bank #(.NUM(NUM_EV)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (ev_set),
        .clr_i   (rd_stb),
        .flags_o (ev_flags)
    );

    assign rd_data = place_events(ev_flags);

    evt_irq_merge u_irq (
        .value_i (rd_data),
        .en_i    (cfg_en),
        .irq_o   (irq)
    );

    // R1 identifier and R2 reserved zeros hold at every edge
    assert_id_reserved_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[5:0] == 6'b001100) && (rd_data[14:12] == 3'b000));

    assert_irq_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !ev_sw && !ev_rxdma && !ev_txrdy && !ev_txunder && !ev_rxmiss
         && !ev_dest && !rx_byte_vld) |=> !irq);

    assert_irq_fall_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> ($past(rd_stb) || ($past(cfg_en) != cfg_en)));

endmodule

// File: tb/sim_evt_status_reg.sv
module sim_evt_status_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_stb = 1'b0;
    logic [15:0] cfg_en = '0;
    logic        ev_sw = 0, ev_rxdma = 0, ev_txrdy = 0, ev_txunder = 0, ev_rxmiss = 0, ev_dest = 0;
    logic        rx_sof = 0, rx_byte_vld = 0;
    logic [15:0] rd_data;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    evt_status_reg u0 (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .cfg_en(cfg_en),
        .ev_sw(ev_sw), .ev_rxdma(ev_rxdma), .ev_txrdy(ev_txrdy),
        .ev_txunder(ev_txunder), .ev_rxmiss(ev_rxmiss), .ev_dest(ev_dest),
        .rx_sof(rx_sof), .rx_byte_vld(rx_byte_vld),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clr_events();
        ev_sw = 0; ev_rxdma = 0; ev_txrdy = 0; ev_txunder = 0; ev_rxmiss = 0; ev_dest = 0;
    endtask

    task automatic do_read(output logic [15:0] val);
        rd_stb = 1;
        #1 val = rd_data;
        tick();
        rd_stb = 0;
    endtask

    task automatic feed(input int n, input bit sof_first);
        for (int i = 0; i < n; i++) begin
            rx_byte_vld = 1;
            rx_sof = (i == 0) && sof_first;
            tick();
        end
        rx_byte_vld = 0;
        rx_sof = 0;
    endtask

    task automatic t_reset();
        chk("R2 reset value", rd_data, 16'h000C);
        chk("R6 reset irq", {15'd0, irq}, 16'd0);
    endtask

    task automatic t_positions();
        logic [15:0] v;
        ev_sw = 1; tick(); clr_events();
        chk("R3 sw bit6", rd_data, 16'h004C);
        ev_rxdma = 1; tick(); clr_events();
        ev_txrdy = 1; tick(); clr_events();
        chk("R3 dma/rdy bits7,8", rd_data, 16'h01CC);
        ev_txunder = 1; ev_rxmiss = 1; tick(); clr_events();
        ev_dest = 1; tick(); clr_events();
        tick();
        chk("R3 sticky all ext events", rd_data, 16'h87CC);
        do_read(v);
        chk("R4 read returns value", v, 16'h87CC);
        chk("R4 cleared after read, R1 id kept", rd_data, 16'h000C);
    endtask

    task automatic t_collide();
        logic [15:0] v;
        ev_rxmiss = 1; tick(); clr_events();
        ev_txunder = 1;
        rd_stb = 1;
        #1 v = rd_data;
        tick();
        rd_stb = 0; clr_events();
        chk("R5 read shows prior value", v, 16'h040C);
        chk("R5 coinciding event kept", rd_data, 16'h020C);
        do_read(v);
        chk("R5 cleared on second read", rd_data, 16'h000C);
    endtask

    task automatic t_irq();
        logic [15:0] v;
        cfg_en = 16'h703F;
        ev_sw = 1; ev_rxdma = 1; ev_txrdy = 1; ev_txunder = 1; ev_rxmiss = 1; ev_dest = 1;
        tick(); clr_events();
        chk("R6 non-event enables ignored", {15'd0, irq}, 16'd0);
        do_read(v);
        cfg_en = 16'h0200;
        ev_sw = 1; tick(); clr_events();
        chk("R6 disabled event no irq", {15'd0, irq}, 16'd0);
        ev_txunder = 1; tick(); clr_events();
        chk("R6 enabled event irq", {15'd0, irq}, 16'd1);
        do_read(v);
        chk("R7 irq low after read", {15'd0, irq}, 16'd0);
        cfg_en = 16'h8000;
        ev_dest = 1; tick(); clr_events();
        chk("R6 bit15 enable irq", {15'd0, irq}, 16'd1);
        do_read(v);
        cfg_en = 16'h0000;
    endtask

    task automatic t_rx128();
        logic [15:0] v;
        feed(127, 1);
        chk("R8 127 bytes no flag", rd_data, 16'h000C);
        feed(1, 0);
        chk("R8 128th byte sets bit11", rd_data, 16'h080C);
        do_read(v);
        feed(40, 0);
        chk("R9 no second flag in frame", rd_data, 16'h000C);
        feed(60, 1);
        feed(127, 1);
        chk("R10 restart count at sof", rd_data, 16'h000C);
        rx_byte_vld = 1;
        rd_stb = 1;
        tick();
        rd_stb = 0; rx_byte_vld = 0;
        chk("R5 R8 128th byte on read kept", rd_data, 16'h080C);
        do_read(v);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_positions();
        t_collide();
        t_irq();
        t_rx128();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule